// File: doc/BRIEF.md
# Nibble-to-Byte Panel Bridge

This block converts a narrow display link into a wider one. A display controller sends four-bit nibbles with a pixel clock, a line strobe and a frame sync. A panel needs an eight-bit data bus. The bridge takes each pair of consecutive nibbles and makes one byte from them, placing the first nibble in the lower half. It drives a panel pixel clock at half the controller's rate. The line strobe and frame sync go to the panel with their values unchanged. The controller's refresh rate and pixel depth are not affected, so the controller needs no new setup.

All controller inputs are sampled on a faster system clock through a synchroniser, and their edges are found there. Nibbles are taken on the falling edge of the controller clock. The panel clock toggles on each rising edge of the controller clock, and a line strobe forces it low, so every line starts with the panel clock low. A finished byte waits in a staging register. It moves to the panel bus on the next rising edge of the panel clock, so it stays stable through the panel's falling capture edge. Every output lags the controller pins by the same three system-clock cycles, so strobe, sync, clock and data stay aligned.

Top module: `nib2byte_bridge`

## Requirements
- R1: The nibble input is 4 bits wide and the panel bus is 8 bits wide. In each byte, bits 3:0 hold the first nibble of the pair and bits 7:4 hold the second.
- R2: The panel clock changes level once for each rising edge of the controller clock, which gives half the input rate. Between such edges it does not change.
- R3: The panel line strobe and panel frame sync repeat the controller's line strobe and frame sync levels unchanged, three system-clock cycles later. This is the same lag as the panel clock and data.
- R4: A rising edge of the line strobe forces the panel clock low. When it falls in the same sampled cycle as a rising edge of the controller clock, the strobe wins and the panel clock goes low.
- R5: A nibble is sampled on each falling edge of the controller clock. The first nibble of a pair is held until the second one arrives, and then the two form a staged byte.
- R6: The panel bus changes only on a low-to-high step of the panel clock. At that step it takes the most recently completed byte.
- R7: A rising edge of the line strobe discards an unpaired nibble, and the next nibble becomes a lower half. A nibble whose falling edge comes in the same sampled cycle as a strobe rising edge is discarded.
- R8: While reset is held low, the panel bus, the panel clock, the panel line strobe and the panel frame sync are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least eight times the controller pixel clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_dat | input | 4 | Nibble from the controller |
| ctl_pclk | input | 1 | Controller pixel clock |
| ctl_lstb | input | 1 | Controller line strobe |
| ctl_fsync | input | 1 | Controller frame sync |
| pnl_dat | output | 8 | Byte bus to the panel |
| pnl_pclk | output | 1 | Panel pixel clock at half the controller rate |
| pnl_lstb | output | 1 | Line strobe to the panel |
| pnl_fsync | output | 1 | Frame sync to the panel |

## Verification
Two events can land in the same sampled cycle: the line strobe's rising edge, and an edge of the controller pixel clock. With a rising clock edge they compete for the divider. With a falling edge they compete for the nibble pairing. The bench provokes each case by driving both pins at the same instant, both in directed sequences and at random line ends. It then judges the result against a reference model in which the strobe takes priority: the panel clock must read low, and the coincident nibble must not appear in any later byte. The bench compares that model with all four outputs on every cycle, and it adds directed checks on known bytes before and after an odd-length line.

// File: rtl/n2b_pkg.sv
// Package n2b_pkg
// Shared constants for the nibble-to-byte panel bridge. It fixes the order
// of the control bits inside the synchronised input vector.
package n2b_pkg;
    localparam int CTL_W     = 3;
    localparam int IDX_PCLK  = 0;
    localparam int IDX_LSTB  = 1;
    localparam int IDX_FSYNC = 2;
endpackage

// File: rtl/sync_chain.sv
// Module sync_chain
// A STAGES-deep flip-flop chain that brings asynchronous inputs into the
// system clock domain. It assumes each input holds its level for
// several system clock cycles. The reset clears every stage.
module sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [STAGES-1:0][W-1:0] stg_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first stage: capture the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= d_in;
            end
        end else begin : g_next
            // later stages: shift the previous stage on
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/pclk_divider.sv
// Module pclk_divider
// A toggle divider that halves the controller pixel clock. A line strobe
// edge clears it and has priority over a coincident clock edge. It
// flags the cycle in which the output is about to go high, so the data
// path can load the next byte in step with that edge.
module pclk_divider (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk_rise,
    input  logic lstb_rise,
    output logic div_q,
    output logic load
);
    assign load = pclk_rise & ~lstb_rise & ~div_q;

    // toggle on each input rising edge; the strobe forces the output low
    always_ff @(posedge clk) begin
        if (!rst_n)         div_q <= 1'b0;
        else if (lstb_rise) div_q <= 1'b0;
        else if (pclk_rise) div_q <= ~div_q;
    end
endmodule

// File: rtl/nibble_pairer.sv
// Module nibble_pairer
// Pairs consecutive nibbles into one byte, with the first nibble in the
// lower half. A finished byte waits in staging until the divider's load
// pulse moves it to the output. A line strobe edge discards any unpaired
// nibble, including one sampled in the same cycle.
module nibble_pairer #(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  nib,
    input  logic              nib_fall,
    input  logic              lstb_rise,
    input  logic              load,
    output logic [BYTE_W-1:0] byte_out
);
    logic              half_q;
    logic [NIB_W-1:0]  lo_q;
    logic [BYTE_W-1:0] stage_q;
    logic [BYTE_W-1:0] out_q;

    // collect nibbles into pairs; the strobe restarts on a lower half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= 1'b0;
            lo_q    <= '0;
            stage_q <= '0;
        end else if (lstb_rise) begin
            half_q <= 1'b0;
        end else if (nib_fall) begin
            if (!half_q) begin
                lo_q   <= nib;
                half_q <= 1'b1;
            end else begin
                stage_q <= {nib, lo_q};
                half_q  <= 1'b0;
            end
        end
    end

    // present the staged byte on the output clock's rising step
    always_ff @(posedge clk) begin
        if (!rst_n)    out_q <= '0;
        else if (load) out_q <= stage_q;
    end

    assign byte_out = out_q;
endmodule

// File: rtl/nib2byte_bridge.sv
// Module nib2byte_bridge
// Turns a nibble-wide display link into a byte-wide one. It synchronises
// the controller pins, finds the clock and strobe edges, halves the pixel
// clock and pairs the nibbles. Every output lags the pins by SYNC_STAGES+1
// system cycles. It assumes the controller clock's half period is at
// least SYNC_STAGES+2 system cycles.
module nib2byte_bridge
    import n2b_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NIB_W-1:0]   ctl_dat,
    input  logic               ctl_pclk,
    input  logic               ctl_lstb,
    input  logic               ctl_fsync,
    output logic [2*NIB_W-1:0] pnl_dat,
    output logic               pnl_pclk,
    output logic               pnl_lstb,
    output logic               pnl_fsync
);
    localparam int IN_W = NIB_W + CTL_W;

    logic [IN_W-1:0]  sync_lvl;
    logic [NIB_W-1:0] nib_lvl;
    logic [CTL_W-1:0] ctl_lvl;
    logic [CTL_W-1:0] ctl_dly;
    logic             pclk_rise;
    logic             pclk_fall;
    logic             lstb_rise;
    logic             div_q;
    logic             load;

    sync_chain #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({ctl_fsync, ctl_lstb, ctl_pclk, ctl_dat}),
        .d_out (sync_lvl)
    );

    assign nib_lvl = sync_lvl[NIB_W-1:0];
    assign ctl_lvl = sync_lvl[IN_W-1:NIB_W];

    // one more stage on the control bits for edge detection and alignment
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_dly <= '0;
        else        ctl_dly <= ctl_lvl;
    end

    assign pclk_rise = ctl_lvl[IDX_PCLK] & ~ctl_dly[IDX_PCLK];
    assign pclk_fall = ~ctl_lvl[IDX_PCLK] & ctl_dly[IDX_PCLK];
    assign lstb_rise = ctl_lvl[IDX_LSTB] & ~ctl_dly[IDX_LSTB];

    pclk_divider u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .pclk_rise (pclk_rise),
        .lstb_rise (lstb_rise),
        .div_q     (div_q),
        .load      (load)
    );

    nibble_pairer #(.NIB_W(NIB_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib       (nib_lvl),
        .nib_fall  (pclk_fall),
        .lstb_rise (lstb_rise),
        .load      (load),
        .byte_out  (pnl_dat)
    );

    assign pnl_pclk  = div_q;
    assign pnl_lstb  = ctl_dly[IDX_LSTB];
    assign pnl_fsync = ctl_dly[IDX_FSYNC];
endmodule

// File: rtl/nib2byte_bridge_chk.sv
// Module nib2byte_bridge_chk
// Property checker bound to nib2byte_bridge. It watches the edge pulses
// and the panel-side outputs.
module nib2byte_bridge_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pclk_rise,
    input logic              lstb_rise,
    input logic              pnl_pclk,
    input logic              pnl_lstb,
    input logic              pnl_fsync,
    input logic [BYTE_W-1:0] pnl_dat
);
    // R2: an unblocked input rising edge flips the panel clock
    assert_clk_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_rise && !lstb_rise) |=> (pnl_pclk != $past(pnl_pclk)));

    // R2: with neither edge present, the panel clock holds
    assert_clk_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pclk_rise && !lstb_rise) |=> $stable(pnl_pclk));

    // R4: a strobe edge leaves the panel clock low
    assert_strobe_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lstb_rise |=> !pnl_pclk);

    // R4: the panel strobe never rises while the panel clock is high
    assert_line_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pnl_lstb) |-> !pnl_pclk);

    // R6: the bus moves only with a rising step of the panel clock
    assert_dat_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pnl_dat) |-> $rose(pnl_pclk));

    // R8: reset clears every panel output
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (pnl_dat == '0 && !pnl_pclk && !pnl_lstb && !pnl_fsync));
endmodule

bind nib2byte_bridge nib2byte_bridge_chk #(.BYTE_W(2 * NIB_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pclk_rise (pclk_rise),
    .lstb_rise (lstb_rise),
    .pnl_pclk  (pnl_pclk),
    .pnl_lstb  (pnl_lstb),
    .pnl_fsync (pnl_fsync),
    .pnl_dat   (pnl_dat)
);

// File: tb/sim_nib2byte_bridge.sv
// Bench for nib2byte_bridge: random lines mixed with directed cases, checked
// against a cycle-level reference model built from the requirements.
module sim_nib2byte_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ctl_dat = '0;
    logic       ctl_pclk = 1'b0;
    logic       ctl_lstb = 1'b0;
    logic       ctl_fsync = 1'b0;
    logic [7:0] pnl_dat;
    logic       pnl_pclk, pnl_lstb, pnl_fsync;

    always #5 clk = ~clk;

    nib2byte_bridge u0 (
        .clk(clk), .rst_n(rst_n), .ctl_dat(ctl_dat), .ctl_pclk(ctl_pclk),
        .ctl_lstb(ctl_lstb), .ctl_fsync(ctl_fsync), .pnl_dat(pnl_dat),
        .pnl_pclk(pnl_pclk), .pnl_lstb(pnl_lstb), .pnl_fsync(pnl_fsync)
    );

    int n_run = 0;
    int n_fail = 0;
    int hp = 4;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: strobe edge wins, pairs low-then-high, 3-cycle lag
    bit       m_pp, m_pl, m_div, m_half;
    bit [3:0] m_lo;
    bit [7:0] m_stage, m_out;
    bit       e_div [3];
    bit       e_lstb [3];
    bit       e_fs [3];
    bit [7:0] e_out [3];

    always @(posedge clk) begin
        bit rp, fp, rl;
        if (!rst_n) begin
            m_pp = 0; m_pl = 0; m_div = 0; m_half = 0; m_lo = 0; m_stage = 0; m_out = 0;
            for (int i = 0; i < 3; i++) begin
                e_div[i] = 0; e_lstb[i] = 0; e_fs[i] = 0; e_out[i] = 0;
            end
        end else begin
            rp = ctl_pclk && !m_pp;
            fp = !ctl_pclk && m_pp;
            rl = ctl_lstb && !m_pl;
            if (rl) begin
                m_div = 0;
                m_half = 0;
            end else begin
                if (rp) begin
                    if (!m_div) m_out = m_stage;
                    m_div = !m_div;
                end
                if (fp) begin
                    if (!m_half) begin m_lo = ctl_dat; m_half = 1; end
                    else begin m_stage = {ctl_dat, m_lo}; m_half = 0; end
                end
            end
            m_pp = ctl_pclk;
            m_pl = ctl_lstb;
            for (int i = 2; i > 0; i--) begin
                e_div[i] = e_div[i-1]; e_lstb[i] = e_lstb[i-1];
                e_fs[i] = e_fs[i-1]; e_out[i] = e_out[i-1];
            end
            e_div[0] = m_div; e_lstb[0] = ctl_lstb; e_fs[0] = ctl_fsync; e_out[0] = m_out;
        end
    end

    // per-cycle comparison of all outputs against the model
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            chk(pnl_pclk == e_div[2], "R2 panel clock", pnl_pclk, e_div[2]);
            chk(pnl_lstb == e_lstb[2], "R3 line strobe", pnl_lstb, e_lstb[2]);
            chk(pnl_fsync == e_fs[2], "R3 frame sync", pnl_fsync, e_fs[2]);
            chk(pnl_dat == e_out[2], "R6 panel byte", pnl_dat, e_out[2]);
        end
    end

    // watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic nib_rise(input logic [3:0] n);
        ctl_dat = n;
        ctl_pclk = 1'b1;
        repeat (hp) @(negedge clk);
    endtask

    task automatic nib_fall();
        ctl_pclk = 1'b0;
        repeat (hp) @(negedge clk);
    endtask

    task automatic strobe(input bit fs);
        ctl_lstb = 1'b1; ctl_fsync = fs;
        repeat (3) @(negedge clk);
        ctl_lstb = 1'b0; ctl_fsync = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe_on_rise(input logic [3:0] n);
        ctl_dat = n; ctl_pclk = 1'b1; ctl_lstb = 1'b1;
        repeat (hp) @(negedge clk);
        ctl_lstb = 1'b0;
        nib_fall();
    endtask

    task automatic strobe_on_fall();
        ctl_pclk = 1'b0; ctl_lstb = 1'b1;
        repeat (hp) @(negedge clk);
        ctl_lstb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        // R8: outputs are zero while reset is held
        chk(pnl_dat == 8'h00 && !pnl_pclk && !pnl_lstb && !pnl_fsync, "R8 reset",
            {pnl_dat, pnl_pclk, pnl_lstb, pnl_fsync}, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (3) @(negedge clk);

        // R1, R5: nibbles 1..4 form 0x21 then 0x43; 0x43 appears at the fifth rise
        for (int k = 1; k <= 4; k++) begin
            nib_rise(4'(k));
            nib_fall();
        end
        nib_rise(4'd5);
        chk(pnl_dat == 8'h43, "R1 R5 byte order", pnl_dat, 8'h43);
        chk(pnl_pclk == 1'b1, "R2 odd rise count", pnl_pclk, 1);
        nib_fall();

        // R3: strobe and sync reach the panel three cycles later
        ctl_lstb = 1'b1; ctl_fsync = 1'b1;
        repeat (3) @(negedge clk);
        chk(pnl_lstb && pnl_fsync, "R3 pass-through", {pnl_lstb, pnl_fsync}, 3);
        // R4: the panel clock is low after the strobe
        chk(pnl_pclk == 1'b0, "R4 line start low", pnl_pclk, 0);
        ctl_lstb = 1'b0; ctl_fsync = 1'b0;
        repeat (3) @(negedge clk);

        // R7: nibble 5 was dropped, so 6,7 pair into 0x76
        nib_rise(4'd6); nib_fall();
        nib_rise(4'd7); nib_fall();
        nib_rise(4'd8);
        chk(pnl_dat == 8'h76, "R7 odd nibble dropped", pnl_dat, 8'h76);
        nib_fall();

        // R4: strobe and clock rise together, and the strobe wins
        strobe_on_rise(4'd9);
        chk(pnl_pclk == 1'b0, "R4 coincident rise", pnl_pclk, 0);
        // R7: strobe on a falling edge drops that nibble; 9 is then also dropped
        nib_rise(4'hA);
        strobe_on_fall();
        nib_rise(4'hB); nib_fall();
        nib_rise(4'hC); nib_fall();
        nib_rise(4'hD);
        chk(pnl_dat == 8'hCB, "R7 coincident fall", pnl_dat, 8'hCB);
        nib_fall();
        strobe(1'b0);

        // random lines with occasional coincidences
        for (int ln = 0; ln < 60; ln++) begin
            int len;
            int endk;
            hp = 4 + int'($urandom % 3);
            len = 1 + int'($urandom % 12);
            if ($urandom % 7 == 0) strobe_on_rise(4'($urandom));
            for (int k = 0; k < len; k++) begin
                nib_rise(4'($urandom));
                nib_fall();
            end
            endk = int'($urandom % 4);
            if (endk == 0) begin
                nib_rise(4'($urandom));
                strobe_on_fall();
            end else begin
                strobe(ln % 8 == 7);
            end
        end
        repeat (6) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule